// File: doc/BRIEF.md
# Dual Halfword Average with Rounding Modes

This block takes two 32-bit operands, each holding two signed 16-bit lanes, and returns the packed per-lane average. Each lane adds its two halfwords into a 17-bit signed sum and halves it with an arithmetic right shift, so the plain result rounds toward negative infinity.

An optional rounding step can adjust that result. It applies only when the lane sum is odd, and only when the variant-enable input is set. A select input picks where the rounding rule comes from: a 2-bit mode field, or a single round-up bit. The result is registered and appears one cycle after the input strobe, together with a valid flag.

Top module: `hwavg_top`

## Requirements
- R1: After synchronous reset, `out_valid` is 0.
- R2: `out_valid` equals the value `in_valid` had one clock earlier, and `out_result` is loaded in the same cycle that `out_valid` rises.
- R3: Each lane sums its two halfwords as a 17-bit signed value, shifts it right by one arithmetically, and wraps the result to 16 bits. Bits [15:0] of the result come from bits [15:0] of both operands. Bits [31:16] come from bits [31:16]. The two lanes are computed independently.
- R4: When `rnd_en` is 0, no lane is adjusted, whatever the other rounding inputs hold.
- R5: When the lane sum is even, no adjustment is made in any mode.
- R6: When `rnd_en`=1, `rnd_sel`=1 and the sum is odd, `rnd_mode` sets the adjustment. Mode 0 adds 1 if the shifted value is non-negative. Mode 1 adds 1 if the shifted value is negative. Mode 2 always adds 1. Mode 3 adds nothing.
- R7: When `rnd_en`=1, `rnd_sel`=0 and the sum is odd, the lane gets 1 added if `rnd_up`=1 and nothing if `rnd_up`=0.
- R8: The adjusted lane never exceeds 16'h7FFF, so the increment never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| op_a | input | 32 | First packed operand |
| op_b | input | 32 | Second packed operand |
| rnd_en | input | 1 | Enables the rounding adjustment |
| rnd_sel | input | 1 | 1: use `rnd_mode`; 0: use `rnd_up` |
| rnd_mode | input | 2 | 0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf |
| rnd_up | input | 1 | Fallback rule: 1 rounds up |
| out_valid | output | 1 | Result valid |
| out_result | output | 32 | Packed averaged result |

## Verification
Every result is due exactly one clock edge after its operands are presented with `in_valid` high. The bench drives the inputs on the falling edge and samples `out_result` and `out_valid` on the next falling edge, after the single register stage has updated. The sweep covers all rounding configurations against a set of lane values that includes odd and even sums, both signs, and the extremes. Each case is checked on both lanes at once, with the two lanes given different values.

// File: rtl/hwavg_pkg.sv
package hwavg_pkg;
    localparam int LANE_W  = 16;
    localparam int LANES   = 2;
    localparam int WORD_W  = LANE_W * LANES;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_ZERO    = 2'd1,
        RM_POSINF  = 2'd2,
        RM_NEGINF  = 2'd3
    } rnd_mode_e;

    typedef struct packed {
        logic      en;
        logic      sel;
        rnd_mode_e mode;
        logic      up;
    } rnd_cfg_t;

    // Whether an odd-sum lane with floor value of the given sign gets +1.
    function automatic logic bump_needed(rnd_cfg_t cfg, logic floor_neg);
        logic b;
        if (!cfg.en)
            b = 1'b0;
        else if (cfg.sel) begin
            unique case (cfg.mode)
                RM_NEAREST: b = !floor_neg;
                RM_ZERO:    b = floor_neg;
                RM_POSINF:  b = 1'b1;
                default:    b = 1'b0;
            endcase
        end else
            b = cfg.up;
        return b;
    endfunction
endpackage

// File: rtl/hwavg_lane.sv
module hwavg_lane
    import hwavg_pkg::*;
#(
    parameter int W = LANE_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  rnd_cfg_t     cfg,
    output logic [W-1:0] avg
);
    localparam int SW = W + 1;

    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] half;
    logic                 odd;
    logic                 bump;

    always_comb begin
        sum  = $signed({a[W-1], a}) + $signed({b[W-1], b});
        half = sum >>> 1;
        odd  = sum[0];
        bump = odd && bump_needed(cfg, half[SW-1]);
        avg  = half[W-1:0] + {{(W-1){1'b0}}, bump};
    end

    // R5: even sums are never adjusted
    even_noadj_chk: assert final (odd || (avg == half[W-1:0]));
    // R8: the increment never wraps past the positive maximum
    no_overflow_chk: assert final (!(bump && half[W-1:0] == {1'b0, {(W-1){1'b1}}}));
endmodule

// File: rtl/hwavg_top.sv
module hwavg_top
    import hwavg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    input  logic        rnd_en,
    input  logic        rnd_sel,
    input  logic [1:0]  rnd_mode,
    input  logic        rnd_up,
    output logic        out_valid,
    output logic [31:0] out_result
);
    rnd_cfg_t          cfg;
    logic [WORD_W-1:0] packed_avg;

    assign cfg = '{en: rnd_en, sel: rnd_sel, mode: rnd_mode_e'(rnd_mode), up: rnd_up};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        hwavg_lane #(.W(LANE_W)) u_lane (
            .a   (op_a[g*LANE_W +: LANE_W]),
            .b   (op_b[g*LANE_W +: LANE_W]),
            .cfg (cfg),
            .avg (packed_avg[g*LANE_W +: LANE_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
        if (in_valid)
            out_result <= packed_avg;
    end

    // R1: valid is low the cycle after reset
    rst_valid_chk: assert property (@(posedge clk) rst |=> !out_valid);
    // R2: valid follows the strobe by one cycle
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst) out_valid == $past(in_valid));
    // R2: the result holds while no strobe arrives
    hold_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(out_result));
    // R4: with rounding disabled the low lane is the plain floor average
    noadj_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !rnd_en) |=>
        out_result[15:0] == 16'($past(($signed({op_a[15], op_a[15:0]}) + $signed({op_b[15], op_b[15:0]})) >>> 1)));
endmodule

// File: tb/hwavg_top_bench.sv
module hwavg_top_bench;
    logic clk = 0;
    logic rst, in_valid, rnd_en, rnd_sel, rnd_up;
    logic [1:0] rnd_mode;
    logic [31:0] op_a, op_b;
    logic out_valid;
    logic [31:0] out_result;
    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    hwavg_top u_hwavg_top (.*);

    function automatic logic [15:0] ref_lane(int a, int b, bit en, bit sel, int mode, bit up);
        int s, f, add;
        s = a + b;
        f = (s - ((s % 2 + 2) % 2)) / 2;
        add = 0;
        if (en && (s % 2 != 0)) begin
            if (sel) begin
                if (mode == 0) add = (f >= 0);
                else if (mode == 1) add = (f < 0);
                else if (mode == 2) add = 1;
            end else add = up;
        end
        return 16'(f + add);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #200000;
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int vals[10] = '{0, 1, -1, 2, -2, 3, -3, 32767, -32768, 12345};
        rst = 1; in_valid = 0; op_a = 0; op_b = 0;
        rnd_en = 0; rnd_sel = 0; rnd_mode = 0; rnd_up = 0;
        repeat (2) @(negedge clk);
        check("R1", {31'd0, out_valid}, 32'd0);
        rst = 0;
        for (int cfgi = 0; cfgi < 16; cfgi++) begin
            for (int i = 0; i < 10; i++) begin
                for (int j = 0; j < 10; j++) begin
                    logic [15:0] el, eh;
                    int a2, b2;
                    a2 = vals[(i + 3) % 10]; b2 = vals[(j + 7) % 10];
                    rnd_en = cfgi[3]; rnd_sel = cfgi[2]; rnd_mode = cfgi[1:0];
                    rnd_up = cfgi[0];
                    op_a = {16'(a2), 16'(vals[i])};
                    op_b = {16'(b2), 16'(vals[j])};
                    in_valid = 1;
                    el = ref_lane(vals[i], vals[j], cfgi[3], cfgi[2], cfgi[1:0], cfgi[0]);
                    eh = ref_lane(a2, b2, cfgi[3], cfgi[2], cfgi[1:0], cfgi[0]);
                    @(negedge clk);
                    // R3 R4 R5 R6 R7 R8 lane results
                    if (!cfgi[3]) check("R4", out_result, {eh, el});
                    else if (cfgi[2]) check("R6", out_result, {eh, el});
                    else check("R7", out_result, {eh, el});
                    check("R2", {31'd0, out_valid}, 32'd1);
                end
            end
        end
        // R3: independent lanes, R5: even sum under round-up
        op_a = 32'h0004_0003; op_b = 32'h0002_0000; rnd_en = 1; rnd_sel = 0; rnd_up = 1;
        @(negedge clk);
        check("R3", out_result, 32'h0003_0002);
        op_a = 32'h0006_FFFE; op_b = 32'h0002_0000;
        @(negedge clk);
        check("R5", out_result, 32'h0004_FFFF);
        // R8: largest odd sum rounds up to the positive maximum without wrapping
        op_a = 32'h7FFF_7FFF; op_b = 32'h7FFE_7FFE; rnd_sel = 1; rnd_mode = 2;
        @(negedge clk);
        check("R8", out_result, 32'h7FFF_7FFF);
        // R2: no strobe, valid drops and the result holds
        in_valid = 0; op_a = 0;
        @(negedge clk);
        check("R2", {31'd0, out_valid}, 32'd0);
        check("R2", out_result, 32'h7FFF_7FFF);
        rst = 1;
        @(negedge clk);
        check("R1", {31'd0, out_valid}, 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule